// File: doc/BRIEF.md
# Exception-Bit Conditional Select Unit

This unit executes a family of select operations that write one of two candidate operands to a destination register. One bit of a 16-bit extended exception field, picked by a 4-bit index, makes the choice. Each candidate is either a 64-bit register read value or a 5-bit signed immediate. Any immediate is sign-extended to the full data width before it is written.

A typical use pairs a load that checks a pointer and records the outcome in an exception bit with a select that follows it. The select returns the loaded address when the check passed, and an immediate zero when it failed. The unit takes already-read register values and decoded fields, and returns a single registered write-back beat one cycle later. The record flag travels beside the result unchanged.

The unit has no sequencing state. Its only storage is the write-back stage, which is either idle (write enable low, previous outputs held) or issuing (write enable high, new result).

Top module: `xsel_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en`, `wr_addr`, `wr_data` and `wr_rc` are all zero.
- R2: `wr_en` equals `in_valid` from one clock earlier. After an issue, `wr_addr` equals the `in_dest` that was presented with it.
- R3: `in_variant` selects the operand form. 2'b00 means both operands are immediates, 2'b01 means the first is an immediate and the second a register, 2'b10 means the first is a register and the second an immediate, and 2'b11 means both are registers. The first operand's register source is `in_ra_val`, and its immediate is `in_imm_a`. The second operand's register source is `in_rb_val`, and its immediate is `in_imm_b`.
- R4: If the selected exception bit is 1, the result is the first operand. If it is 0, the result is the second operand.
- R5: `in_xbi` picks exception bit number 32 plus `in_xbi`. That bit is held in `in_xfield[in_xbi]`, so index 0 reads bit 32 and index 15 reads bit 47.
- R6: An immediate is a 5-bit two's-complement value from -16 to +15, sign-extended to 64 bits. For example, 5'b10000 gives 64'hFFFF_FFFF_FFFF_FFF0 and 5'b01111 gives 64'hF.
- R7: A selected immediate of 0 gives an all-zero 64-bit result.
- R8: After an issue, `wr_rc` equals the `in_rc` that was presented with it.
- R9: In a cycle with `in_valid` low, `wr_addr`, `wr_data` and `wr_rc` keep their values and `wr_en` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue a select this cycle |
| in_variant | input | 2 | Operand form (see R3) |
| in_ra_val | input | 64 | Register value for the first operand |
| in_rb_val | input | 64 | Register value for the second operand |
| in_imm_a | input | 5 | Signed immediate for the first operand |
| in_imm_b | input | 5 | Signed immediate for the second operand |
| in_xbi | input | 4 | Exception bit index (bit 32 + index) |
| in_xfield | input | 16 | Exception bits 32..47, bit 32 at index 0 |
| in_dest | input | 5 | Destination register number |
| in_rc | input | 1 | Record flag, passed through |
| wr_en | output | 1 | Write-back enable |
| wr_addr | output | 5 | Write-back register number |
| wr_data | output | 64 | Selected, sign-extended result |
| wr_rc | output | 1 | Record flag of the written result |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path, 5-bit immediates, a 16-bit exception field and 5-bit register numbers. These values bring the extremes of the immediate range into reach, so sign extension across all 59 upper bits can be observed. They also allow a one-hot field at both end indices, so an off-by-one in the bit pick would show up as a wrong selection. Each operand form is driven with the selecting bit both set and clear, using register values that differ from the immediates, so that a swapped form bit would be caught.

// File: rtl/xsel_pkg.sv
package xsel_pkg;
    // bit 1: first operand comes from a register; bit 0: second operand does
    typedef enum logic [1:0] {
        SEL_II = 2'b00,
        SEL_IR = 2'b01,
        SEL_RI = 2'b10,
        SEL_RR = 2'b11
    } sel_form_e;
endpackage

// File: rtl/xsel_operand.sv
module xsel_operand #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 5
) (
    input  logic             use_reg,
    input  logic [XLEN-1:0]  reg_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  opnd
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        opnd    = use_reg ? reg_val : imm_ext;
    end
endmodule

// File: rtl/xsel_bitpick.sv
module xsel_bitpick #(
    parameter int FIELD_W = 16,
    parameter int IDX_W   = $clog2(FIELD_W)
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [IDX_W-1:0]   idx,
    output logic               bit_on
);
    logic [FIELD_W-1:0] hit;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_hit
        assign hit[i] = field[i] && (idx == IDX_W'(i));
    end

    assign bit_on = |hit;
endmodule

// File: rtl/xsel_unit.sv
module xsel_unit
    import xsel_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int IMM_W   = 5,
    parameter int FIELD_W = 16,
    parameter int RADDR_W = 5,
    localparam int IDX_W  = $clog2(FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_variant,
    input  logic [XLEN-1:0]    in_ra_val,
    input  logic [XLEN-1:0]    in_rb_val,
    input  logic [IMM_W-1:0]   in_imm_a,
    input  logic [IMM_W-1:0]   in_imm_b,
    input  logic [IDX_W-1:0]   in_xbi,
    input  logic [FIELD_W-1:0] in_xfield,
    input  logic [RADDR_W-1:0] in_dest,
    input  logic               in_rc,
    output logic               wr_en,
    output logic [RADDR_W-1:0] wr_addr,
    output logic [XLEN-1:0]    wr_data,
    output logic               wr_rc
);
    localparam int N_OPND = 2;

    sel_form_e        form;
    logic [XLEN-1:0]  reg_src [N_OPND];
    logic [IMM_W-1:0] imm_src [N_OPND];
    logic [XLEN-1:0]  opnd    [N_OPND];
    logic             cond_on;
    logic [XLEN-1:0]  result;

    assign form       = sel_form_e'(in_variant);
    assign reg_src[0] = in_ra_val;
    assign reg_src[1] = in_rb_val;
    assign imm_src[0] = in_imm_a;
    assign imm_src[1] = in_imm_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        xsel_operand #(
            .XLEN  (XLEN),
            .IMM_W (IMM_W)
        ) opnd_i (
            .use_reg (form[N_OPND-1-g]),
            .reg_val (reg_src[g]),
            .imm     (imm_src[g]),
            .opnd    (opnd[g])
        );
    end

    xsel_bitpick #(
        .FIELD_W (FIELD_W),
        .IDX_W   (IDX_W)
    ) pick_i (
        .field  (in_xfield),
        .idx    (in_xbi),
        .bit_on (cond_on)
    );

    assign result = cond_on ? opnd[0] : opnd[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_rc   <= 1'b0;
        end else begin
            wr_en <= in_valid;
            if (in_valid) begin
                wr_addr <= in_dest;
                wr_data <= result;
                wr_rc   <= in_rc;
            end
        end
    end
endmodule

// File: rtl/xsel_unit_chk.sv
module xsel_unit_chk #(
    parameter int XLEN    = 64,
    parameter int IMM_W   = 5,
    parameter int FIELD_W = 16,
    parameter int RADDR_W = 5,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_variant,
    input logic [XLEN-1:0]    in_ra_val,
    input logic [XLEN-1:0]    in_rb_val,
    input logic [IMM_W-1:0]   in_imm_a,
    input logic [IMM_W-1:0]   in_imm_b,
    input logic [IDX_W-1:0]   in_xbi,
    input logic [FIELD_W-1:0] in_xfield,
    input logic [RADDR_W-1:0] in_dest,
    input logic               in_rc,
    input logic               wr_en,
    input logic [RADDR_W-1:0] wr_addr,
    input logic [XLEN-1:0]    wr_data,
    input logic               wr_rc
);
    localparam int EXT_W = XLEN - IMM_W;

    p_wr_en_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == $past(in_valid) || !$past(rst_n));

    p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_addr == $past(in_dest));

    p_select_rr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_variant == 2'b11) |=>
        wr_data == ($past(in_xfield[in_xbi]) ? $past(in_ra_val) : $past(in_rb_val)));

    p_imm_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_variant == 2'b00 && !in_xfield[in_xbi]) |=>
        wr_data == {{EXT_W{$past(in_imm_b[IMM_W-1])}}, $past(in_imm_b)});

    p_rc_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_rc == $past(in_rc));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_data) && $stable(wr_addr) && $stable(wr_rc));
endmodule

bind xsel_unit xsel_unit_chk #(
    .XLEN    (XLEN),
    .IMM_W   (IMM_W),
    .FIELD_W (FIELD_W),
    .RADDR_W (RADDR_W),
    .IDX_W   (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_variant (in_variant),
    .in_ra_val  (in_ra_val),
    .in_rb_val  (in_rb_val),
    .in_imm_a   (in_imm_a),
    .in_imm_b   (in_imm_b),
    .in_xbi     (in_xbi),
    .in_xfield  (in_xfield),
    .in_dest    (in_dest),
    .in_rc      (in_rc),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_rc      (wr_rc)
);

// File: tb/xsel_unit_tb_top.sv
module xsel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_variant = '0;
    logic [63:0] in_ra_val = '0;
    logic [63:0] in_rb_val = '0;
    logic [4:0]  in_imm_a = '0;
    logic [4:0]  in_imm_b = '0;
    logic [3:0]  in_xbi = '0;
    logic [15:0] in_xfield = '0;
    logic [4:0]  in_dest = '0;
    logic        in_rc = 1'b0;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] wr_data;
    logic        wr_rc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xsel_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_variant(in_variant),
        .in_ra_val(in_ra_val), .in_rb_val(in_rb_val), .in_imm_a(in_imm_a),
        .in_imm_b(in_imm_b), .in_xbi(in_xbi), .in_xfield(in_xfield),
        .in_dest(in_dest), .in_rc(in_rc), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_rc(wr_rc)
    );

    function automatic logic [63:0] sext5(input logic [4:0] v);
        logic signed [63:0] s;
        s = 64'($signed(v));
        return s;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one issue at a falling edge, sample at the next falling edge
    task automatic issue(input logic [1:0] form, input logic [63:0] ra, input logic [63:0] rb,
                         input logic [4:0] ia, input logic [4:0] ib, input logic [3:0] xbi,
                         input logic [15:0] xf, input logic [4:0] dest, input logic rc);
        @(negedge clk);
        in_valid = 1'b1; in_variant = form; in_ra_val = ra; in_rb_val = rb;
        in_imm_a = ia; in_imm_b = ib; in_xbi = xbi; in_xfield = xf;
        in_dest = dest; in_rc = rc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    localparam logic [63:0] RA = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] RB = 64'hFEDC_BA98_7654_3210;

    task automatic t_reset;
        check64("R1 wr_en", 64'(wr_en), 64'd0);
        check64("R1 wr_addr", 64'(wr_addr), 64'd0);
        check64("R1 wr_data", wr_data, 64'd0);
        check64("R1 wr_rc", 64'(wr_rc), 64'd0);
    endtask

    task automatic t_reg_reg;
        issue(2'b11, RA, RB, 5'd3, 5'd4, 4'd9, 16'h0200, 5'd26, 1'b0);
        check64("R4 RR bit set", wr_data, RA);
        check64("R2 wr_en", 64'(wr_en), 64'd1);
        check64("R2 wr_addr", 64'(wr_addr), 64'd26);
        issue(2'b11, RA, RB, 5'd3, 5'd4, 4'd9, 16'hFDFF, 5'd7, 1'b0);
        check64("R4 RR bit clear", wr_data, RB);
        check64("R2 wr_addr 2", 64'(wr_addr), 64'd7);
    endtask

    task automatic t_forms;
        issue(2'b00, RA, RB, 5'd6, 5'd9, 4'd1, 16'h0002, 5'd1, 1'b0);
        check64("R3 II first", wr_data, 64'd6);
        issue(2'b01, RA, RB, 5'd6, 5'd9, 4'd1, 16'h0000, 5'd1, 1'b0);
        check64("R3 IR second reg", wr_data, RB);
        issue(2'b01, RA, RB, 5'd6, 5'd9, 4'd1, 16'h0002, 5'd1, 1'b0);
        check64("R3 IR first imm", wr_data, 64'd6);
        issue(2'b10, RA, RB, 5'd6, 5'd9, 4'd1, 16'h0002, 5'd1, 1'b0);
        check64("R3 RI first reg", wr_data, RA);
        issue(2'b10, RA, RB, 5'd6, 5'd9, 4'd1, 16'h0000, 5'd1, 1'b0);
        check64("R3 RI second imm", wr_data, 64'd9);
    endtask

    task automatic t_index_edges;
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd0, 16'h0001, 5'd2, 1'b0);
        check64("R5 index0 bit32", wr_data, RA);
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd15, 16'h0001, 5'd2, 1'b0);
        check64("R5 index15 sees clear", wr_data, RB);
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd15, 16'h8000, 5'd2, 1'b0);
        check64("R5 index15 bit47", wr_data, RA);
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd14, 16'h8000, 5'd2, 1'b0);
        check64("R5 index14 neighbour", wr_data, RB);
    endtask

    task automatic t_sign_ext;
        issue(2'b00, RA, RB, 5'b10000, 5'b01111, 4'd3, 16'h0008, 5'd4, 1'b0);
        check64("R6 imm -16", wr_data, 64'hFFFF_FFFF_FFFF_FFF0);
        check64("R6 imm -16 model", wr_data, sext5(5'b10000));
        issue(2'b00, RA, RB, 5'b10000, 5'b01111, 4'd3, 16'h0000, 5'd4, 1'b0);
        check64("R6 imm +15", wr_data, 64'h0000_0000_0000_000F);
        issue(2'b10, RA, RB, 5'd0, 5'b11111, 4'd5, 16'h0000, 5'd4, 1'b0);
        check64("R6 imm -1", wr_data, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_zero_imm;
        // pointer check failed: bit clear, second operand immediate 0
        issue(2'b10, RA, RB, 5'd0, 5'd0, 4'd9, 16'h0000, 5'd26, 1'b0);
        check64("R7 zero on failed check", wr_data, 64'd0);
        issue(2'b01, RA, RB, 5'd0, 5'd5, 4'd9, 16'h0200, 5'd26, 1'b0);
        check64("R7 zero first imm", wr_data, 64'd0);
    endtask

    task automatic t_rc;
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd0, 16'h0001, 5'd11, 1'b1);
        check64("R8 rc set", 64'(wr_rc), 64'd1);
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd0, 16'h0001, 5'd11, 1'b0);
        check64("R8 rc clear", 64'(wr_rc), 64'd0);
    endtask

    task automatic t_idle_hold;
        issue(2'b11, RA, RB, 5'd0, 5'd0, 4'd0, 16'h0001, 5'd19, 1'b1);
        @(negedge clk);
        in_variant = 2'b11; in_ra_val = 64'hDEAD; in_rb_val = 64'hBEEF;
        in_dest = 5'd3; in_rc = 1'b0; in_xfield = 16'h0000;
        @(negedge clk);
        check64("R9 wr_en low", 64'(wr_en), 64'd0);
        check64("R9 data held", wr_data, RA);
        check64("R9 addr held", 64'(wr_addr), 64'd19);
        check64("R9 rc held", 64'(wr_rc), 64'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_reg_reg;
        t_forms;
        t_index_edges;
        t_sign_ext;
        t_zero_imm;
        t_rc;
        t_idle_hold;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule